// File: doc/BRIEF.md
# Serial Control and Status Byte Port

This block is the serial register port of a system-basis device. An external host drives an active-low select, a serial clock and a data line. Each frame moves one byte in each direction, most significant bit first. The byte received from the host sets the device's operating mode, three high-side switch requests, a LIN termination option and two LIN slope bits. The byte sent back is a status snapshot. It is frozen at the moment the select goes low, so the host always reads a coherent set of flags. Its top bit tells the host whether the remaining bits describe the cause of a pending interrupt or the live state.

All serial pins cross into the system clock domain through a synchronizer chain, and every decision is taken on the system clock. A frame state machine has three states:

- `FR_IDLE`: select high. It moves to `FR_SHIFT` on a select falling edge, which also loads the status snapshot.
- `FR_SHIFT`: bits are being counted. It returns to `FR_IDLE` on a select rising edge, which commits the frame if exactly eight bits arrived. It moves to `FR_OVER` on a ninth rising clock edge.
- `FR_OVER`: an overlong frame. It waits for the select rising edge and then returns to `FR_IDLE` without committing.

A separate gap timer checks the time between select rising edges. It rejects any frame whose select rises too soon after the previous one. When the committed mode code is the "normal with watchdog clear" value, the block emits a one-cycle watchdog-clear pulse.

Top module: `sbc_spi_ctrl`

## Requirements
- R1: After reset, the outputs are `mode_o`=00, `hs_on_o`=000, `lin_slope_o`=00 and `lin_term_on_o`=1. `wd_clr_o`, `timing_err_o` and `spi_miso_o` are all 0.
- R2: During a frame, `spi_miso_o` presents the captured status byte MSB first, one bit per serial clock period, and changes after the falling serial clock edge. The byte layout is: bit7 `irq_pend_i`, bit6 `lin_evt_i`, bit5 `vsup_ov_i`, bit4 `vsup_uv_i`, bit3 `therm_warn_i`, bit2 `hs_stat_i`, bits1..0 `lin_stat_i[1:0]`. While select is high, `spi_miso_o` is 0.
- R3: The status byte is captured when select falls. Status input changes made later in the same frame do not appear in that frame's read byte.
- R4: In the first frame after reset, bit4 of the read byte carries `bat_fail_i` instead of `vsup_uv_i`. Every later frame carries `vsup_uv_i`.
- R5: The byte received MSB first on `spi_mosi_i` (sampled on rising serial clock edges) is applied when select rises, with this layout: bits7..6 to `lin_slope_o[1:0]`, bit5 to the termination-off option, bits4..2 to the switch requests HS3, HS2 and HS1, bits1..0 to `mode_o`.
- R6: `hs_on_o[k]` is 1 only when the stored request for that switch is 1 and `hs_in_i[k]` is 1. Index 2 is HS3 and index 0 is HS1.
- R7: `lin_term_on_o` is 0 only when the stored termination-off bit is 1 and `mode_o` is sleep (00) or stop (01). Otherwise it is 1.
- R8: Committing mode code 10 produces exactly one system clock cycle of `wd_clr_o`. Committing any other code produces none.
- R9: A frame with any bit count other than eight leaves every control output unchanged and produces no `wd_clr_o` pulse.
- R10: A select rising edge fewer than `MIN_GAP_CLKS` system clocks after the previous one discards the frame and sets `timing_err_o` to 1. A frame that ends after a long enough gap sets `timing_err_o` back to 0. The first frame after reset is never early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| spi_sclk_i | input | 1 | Serial clock, idle low |
| spi_csn_i | input | 1 | Active-low frame select |
| spi_mosi_i | input | 1 | Serial data from host |
| spi_miso_o | output | 1 | Serial data to host |
| irq_pend_i | input | 1 | Interrupt pending; read bit 7 |
| lin_evt_i | input | 1 | LIN wake-up or LIN fault |
| vsup_ov_i | input | 1 | Supply overvoltage |
| vsup_uv_i | input | 1 | Supply undervoltage |
| bat_fail_i | input | 1 | Battery-fail flag, read in the first frame only |
| therm_warn_i | input | 1 | Thermal warning |
| hs_stat_i | input | 1 | High-side status |
| lin_stat_i | input | 2 | LIN status bits |
| hs_in_i | input | 3 | Per-switch enable inputs (index 2 = HS3) |
| mode_o | output | 2 | Operating mode: 00 sleep, 01 stop, 10 normal with clear, 11 normal |
| hs_on_o | output | 3 | High-side switch drive (index 2 = HS3) |
| lin_slope_o | output | 2 | LIN slope select |
| lin_term_on_o | output | 1 | LIN termination pull-up connected |
| wd_clr_o | output | 1 | Watchdog-clear strobe |
| timing_err_o | output | 1 | Result of the last frame-end gap check |

## Verification
The bench builds the block with `MIN_GAP_CLKS` = 150 and a two-stage synchronizer, and drives the serial clock at a half period of six system clocks. With these values, an ordinary frame lasts about 110 system clocks. Two frames issued back to back therefore violate the gap rule, and the same frames spaced with a long idle satisfy it. This brings both outcomes of R10 within a short run. The half period also leaves several clocks of margin after the synchronizer delay, so the host model can sample every read bit cleanly.

// File: rtl/sbc_spi_pkg.sv
package sbc_spi_pkg;

    localparam int FRAME_BITS = 8;

    typedef enum logic [1:0] {
        MODE_SLEEP  = 2'b00,
        MODE_STOP   = 2'b01,
        MODE_RUN_WD = 2'b10,
        MODE_RUN    = 2'b11
    } sbc_mode_e;

    // Field order follows the received byte, MSB first.
    typedef struct packed {
        logic [1:0] slope;
        logic       term_off;
        logic [2:0] hs_req;
        sbc_mode_e  mode;
    } ctrl_word_t;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_SHIFT,
        FR_OVER
    } frame_st_e;

endpackage

// File: rtl/sbc_spi_sync.sv
module sbc_spi_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                stage_q[s] <= RST_VAL;
            end else if (s == 0) begin
                stage_q[s] <= d_i;
            end else begin
                stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/sbc_spi_frame.sv
module sbc_spi_frame
    import sbc_spi_pkg::*;
(
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  sclk_s_i,
    input  logic                  mosi_s_i,
    input  logic                  csn_s_i,
    input  logic [FRAME_BITS-1:0] status_i,
    output logic                  miso_o,
    output logic                  cs_fall_o,
    output logic                  cs_rise_o,
    output logic                  frame_good_o,
    output logic [FRAME_BITS-1:0] rx_byte_o
);

    localparam int CNT_W = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

    frame_st_e             state_q, state_d;
    logic                  csn_d_q, sclk_d_q;
    logic [CNT_W-1:0]      cnt_q;
    logic [FRAME_BITS-1:0] rx_q, tx_q;
    logic                  cs_fall, cs_rise, sclk_rise, sclk_fall;

    assign cs_fall   =  csn_d_q & ~csn_s_i;
    assign cs_rise   = ~csn_d_q &  csn_s_i;
    assign sclk_rise = ~sclk_d_q &  sclk_s_i;
    assign sclk_fall =  sclk_d_q & ~sclk_s_i;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FR_IDLE:  if (cs_fall) state_d = FR_SHIFT;
            FR_SHIFT: begin
                if (cs_rise) begin
                    state_d = FR_IDLE;
                end else if (sclk_rise && cnt_q == CNT_FULL) begin
                    state_d = FR_OVER;
                end
            end
            FR_OVER:  if (cs_rise) state_d = FR_IDLE;
            default:  state_d = FR_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= FR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Edge history and shift datapath
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            csn_d_q  <= 1'b1;
            sclk_d_q <= 1'b0;
            cnt_q    <= '0;
            rx_q     <= '0;
            tx_q     <= '0;
        end else begin
            csn_d_q  <= csn_s_i;
            sclk_d_q <= sclk_s_i;
            if (cs_fall) begin
                tx_q  <= status_i;
                rx_q  <= '0;
                cnt_q <= '0;
            end else if (state_q == FR_SHIFT) begin
                if (sclk_rise && cnt_q < CNT_FULL) begin
                    rx_q  <= {rx_q[FRAME_BITS-2:0], mosi_s_i};
                    cnt_q <= cnt_q + 1'b1;
                end
                if (sclk_fall) begin
                    tx_q <= {tx_q[FRAME_BITS-2:0], 1'b0};
                end
            end
        end
    end

    // Outputs
    always_comb begin
        miso_o       = (state_q != FR_IDLE) & tx_q[FRAME_BITS-1];
        cs_fall_o    = cs_fall;
        cs_rise_o    = cs_rise;
        frame_good_o = (state_q == FR_SHIFT) && cs_rise && (cnt_q == CNT_FULL);
        rx_byte_o    = rx_q;
    end

    // R2: the outgoing byte only moves on a serial clock fall or a fresh capture
    a_r2_tx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sclk_fall && !cs_fall) |=> $stable(tx_q));

    // R9: a ninth clock edge pushes the frame into the overrun state
    a_r9_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == FR_SHIFT && !cs_rise && sclk_rise && cnt_q == CNT_FULL)
        |=> (state_q == FR_OVER));

endmodule

// File: rtl/sbc_spi_gap.sv
module sbc_spi_gap #(
    parameter int MIN_GAP_CLKS = 1875
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic rise_i,
    output logic gap_ok_o
);

    localparam int GAP_W = $clog2(MIN_GAP_CLKS + 1);
    localparam logic [GAP_W-1:0] GAP_LIM = GAP_W'(MIN_GAP_CLKS);

    logic [GAP_W-1:0] cnt_q;

    // Starts saturated so the first frame after reset is accepted.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= GAP_LIM;
        end else if (rise_i) begin
            cnt_q <= '0;
        end else if (cnt_q < GAP_LIM) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign gap_ok_o = (cnt_q >= GAP_LIM);

endmodule

// File: rtl/sbc_spi_ctrl.sv
module sbc_spi_ctrl
    import sbc_spi_pkg::*;
#(
    parameter int MIN_GAP_CLKS = 1875,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       spi_sclk_i,
    input  logic       spi_csn_i,
    input  logic       spi_mosi_i,
    output logic       spi_miso_o,
    input  logic       irq_pend_i,
    input  logic       lin_evt_i,
    input  logic       vsup_ov_i,
    input  logic       vsup_uv_i,
    input  logic       bat_fail_i,
    input  logic       therm_warn_i,
    input  logic       hs_stat_i,
    input  logic [1:0] lin_stat_i,
    input  logic [2:0] hs_in_i,
    output logic [1:0] mode_o,
    output logic [2:0] hs_on_o,
    output logic [1:0] lin_slope_o,
    output logic       lin_term_on_o,
    output logic       wd_clr_o,
    output logic       timing_err_o
);

    logic [2:0]            pins_s;
    logic                  sclk_s, csn_s, mosi_s;
    logic [FRAME_BITS-1:0] status_byte, rx_byte;
    logic                  cs_fall, cs_rise, frame_good, gap_ok, commit;
    ctrl_word_t            ctrl_q;
    logic                  wd_q, terr_q, first_q;

    sbc_spi_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    ({spi_sclk_i, spi_csn_i, spi_mosi_i}),
        .q_o    (pins_s)
    );

    assign {sclk_s, csn_s, mosi_s} = pins_s;

    // Bit 4 carries the battery flag until the first capture after reset.
    assign status_byte = {irq_pend_i, lin_evt_i, vsup_ov_i,
                          (first_q ? bat_fail_i : vsup_uv_i),
                          therm_warn_i, hs_stat_i, lin_stat_i};

    sbc_spi_frame u_frame (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .sclk_s_i     (sclk_s),
        .mosi_s_i     (mosi_s),
        .csn_s_i      (csn_s),
        .status_i     (status_byte),
        .miso_o       (spi_miso_o),
        .cs_fall_o    (cs_fall),
        .cs_rise_o    (cs_rise),
        .frame_good_o (frame_good),
        .rx_byte_o    (rx_byte)
    );

    sbc_spi_gap #(
        .MIN_GAP_CLKS (MIN_GAP_CLKS)
    ) u_gap (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .rise_i   (cs_rise),
        .gap_ok_o (gap_ok)
    );

    assign commit = frame_good & gap_ok;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q  <= '0;
            wd_q    <= 1'b0;
            terr_q  <= 1'b0;
            first_q <= 1'b1;
        end else begin
            if (commit) begin
                ctrl_q <= ctrl_word_t'(rx_byte);
            end
            wd_q <= commit && (sbc_mode_e'(rx_byte[1:0]) == MODE_RUN_WD);
            if (cs_rise) begin
                terr_q <= ~gap_ok;
            end
            if (cs_fall) begin
                first_q <= 1'b0;
            end
        end
    end

    always_comb begin
        mode_o        = ctrl_q.mode;
        hs_on_o       = ctrl_q.hs_req & hs_in_i;
        lin_slope_o   = ctrl_q.slope;
        lin_term_on_o = ~(ctrl_q.term_off &
                          (ctrl_q.mode == MODE_SLEEP || ctrl_q.mode == MODE_STOP));
        wd_clr_o      = wd_q;
        timing_err_o  = terr_q;
    end

    // R8: the strobe lasts one cycle
    a_r8_wd_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wd_clr_o |=> !wd_clr_o);

    // R8: the strobe only accompanies the clear-mode code
    a_r8_wd_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wd_clr_o |-> (mode_o == 2'b10));

    // R10: a well-formed frame that ends too early changes nothing
    a_r10_gap_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frame_good && !gap_ok) |=> ($stable(ctrl_q) && !wd_clr_o));

endmodule

// File: tb/sbc_spi_ctrl_bench.sv
module sbc_spi_ctrl_bench;

    localparam int MIN_GAP = 150;
    localparam int HALF    = 6;
    localparam int IDLE    = 200;
    localparam int NVEC    = 6;

    typedef struct packed {
        logic [7:0] wr;
        logic [7:0] st;
        logic [2:0] hsin;
        logic [7:0] exp_rd;
        logic [1:0] exp_mode;
        logic [2:0] exp_hs;
        logic [1:0] exp_slope;
        logic       exp_term;
        logic       exp_wd;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{8'hFF, 8'hA5, 3'b101, 8'hA5, 2'b11, 3'b101, 2'b11, 1'b1, 1'b0},
        '{8'h68, 8'h5A, 3'b111, 8'h5A, 2'b00, 3'b010, 2'b01, 1'b0, 1'b0},
        '{8'h91, 8'h13, 3'b111, 8'h13, 2'b01, 3'b100, 2'b10, 1'b1, 1'b0},
        '{8'h25, 8'hFF, 3'b110, 8'hFF, 2'b01, 3'b000, 2'b00, 1'b0, 1'b0},
        '{8'h02, 8'h00, 3'b111, 8'h00, 2'b10, 3'b000, 2'b00, 1'b1, 1'b1},
        '{8'hF2, 8'h80, 3'b111, 8'h80, 2'b10, 3'b100, 2'b11, 1'b1, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
    logic       miso;
    logic [7:0] st_drv = 8'h00;
    logic       bat_drv = 1'b0;
    logic [2:0] hsin = 3'b111;
    logic [1:0] mode, slope;
    logic [2:0] hs_on;
    logic       term_on, wd_clr, terr;

    int checks = 0;
    int fails  = 0;
    int wd_hi  = 0;

    always #4 clk = ~clk;

    always @(posedge clk) if (wd_clr) wd_hi++;

    sbc_spi_ctrl #(
        .MIN_GAP_CLKS (MIN_GAP),
        .SYNC_STAGES  (2)
    ) u_sbc_spi_ctrl (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .spi_sclk_i    (sclk),
        .spi_csn_i     (csn),
        .spi_mosi_i    (mosi),
        .spi_miso_o    (miso),
        .irq_pend_i    (st_drv[7]),
        .lin_evt_i     (st_drv[6]),
        .vsup_ov_i     (st_drv[5]),
        .vsup_uv_i     (st_drv[4]),
        .bat_fail_i    (bat_drv),
        .therm_warn_i  (st_drv[3]),
        .hs_stat_i     (st_drv[2]),
        .lin_stat_i    (st_drv[1:0]),
        .hs_in_i       (hsin),
        .mode_o        (mode),
        .hs_on_o       (hs_on),
        .lin_slope_o   (slope),
        .lin_term_on_o (term_on),
        .wd_clr_o      (wd_clr),
        .timing_err_o  (terr)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic frame(input logic [7:0] wr, input int nbits,
                         input bit mid_en, input logic [7:0] mid_st,
                         output logic [7:0] rd);
        rd = '0;
        @(negedge clk) csn = 1'b0;
        repeat (6) @(negedge clk);
        for (int b = 0; b < nbits; b++) begin
            mosi = (b < 8) ? wr[7-b] : 1'b0;
            repeat (HALF) @(negedge clk);
            rd = {rd[6:0], miso};
            sclk = 1'b1;
            if (mid_en && b == 0) st_drv = mid_st;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        csn = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        int         wd0;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1: reset state
        chk("R1 mode", mode, 0);
        chk("R1 hs_on", hs_on, 0);
        chk("R1 slope", slope, 0);
        chk("R1 term_on", term_on, 1);
        chk("R1 wd_clr", wd_clr, 0);
        chk("R1 timing_err", terr, 0);
        chk("R1 miso idle", miso, 0);

        // R4: first read substitutes the battery flag on bit 4
        st_drv = 8'h00; bat_drv = 1'b1;
        frame(8'h03, 8, 1'b0, 8'h00, rd);
        chk("R4 first read", rd, 8'h10);
        chk("R10 first frame not early", terr, 0);
        repeat (IDLE) @(negedge clk);
        frame(8'h03, 8, 1'b0, 8'h00, rd);
        chk("R4 later read", rd, 8'h00);
        bat_drv = 1'b0;
        repeat (IDLE) @(negedge clk);

        // R2 R5 R6 R7 R8: table walk
        for (int i = 0; i < NVEC; i++) begin
            st_drv = VECS[i].st;
            hsin   = VECS[i].hsin;
            wd0    = wd_hi;
            frame(VECS[i].wr, 8, 1'b0, 8'h00, rd);
            chk("R2 read byte", rd, VECS[i].exp_rd);
            chk("R5 mode", mode, VECS[i].exp_mode);
            chk("R6 hs_on", hs_on, VECS[i].exp_hs);
            chk("R5 slope", slope, VECS[i].exp_slope);
            chk("R7 term_on", term_on, VECS[i].exp_term);
            chk("R8 wd cycles", wd_hi - wd0, VECS[i].exp_wd);
            chk("R10 timing_err clear", terr, 0);
            repeat (IDLE) @(negedge clk);
        end
        chk("R2 miso idle after frames", miso, 0);

        // R3: status change mid-frame is not seen
        st_drv = 8'h3C;
        frame(8'h03, 8, 1'b1, 8'hC3, rd);
        chk("R3 snapshot", rd, 8'h3C);
        repeat (IDLE) @(negedge clk);

        // R9: short and long frames are discarded (state is mode 11, hs 000, slope 00)
        hsin = 3'b111;
        wd0  = wd_hi;
        frame(8'h02, 7, 1'b0, 8'h00, rd);
        chk("R9 short mode", mode, 2'b11);
        repeat (IDLE) @(negedge clk);
        frame(8'hFE, 9, 1'b0, 8'h00, rd);
        chk("R9 long mode", mode, 2'b11);
        chk("R9 long hs", hs_on, 0);
        chk("R9 long slope", slope, 0);
        chk("R9 no wd", wd_hi - wd0, 0);
        repeat (IDLE) @(negedge clk);

        // R10: early frame end is rejected
        frame(8'h1F, 8, 1'b0, 8'h00, rd);
        chk("R10 ok frame hs", hs_on, 3'b111);
        wd0 = wd_hi;
        frame(8'h02, 8, 1'b0, 8'h00, rd);
        chk("R10 early flag", terr, 1);
        chk("R10 early mode", mode, 2'b11);
        chk("R10 early hs", hs_on, 3'b111);
        chk("R10 early no wd", wd_hi - wd0, 0);
        repeat (IDLE) @(negedge clk);
        frame(8'h02, 8, 1'b0, 8'h00, rd);
        chk("R10 recovered flag", terr, 0);
        chk("R10 recovered mode", mode, 2'b10);
        chk("R8 recovered wd", wd_hi - wd0, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule